// File: doc/BRIEF.md
# Stage Instruction Dispatcher with Ordering Tokens

This block accepts a stream of 128-bit instructions, decodes each one and places it in one of three per-stage queues: load, compute or store. Each queue feeds a stage front end that holds the instruction at the head until its dependence flags are satisfied. It then issues the instruction to the stage and waits for the stage's completion pulse before it issues the next one.

Four single-bit token channels order the stages. They are load-to-compute, compute-to-load, compute-to-store and store-to-compute, and each is kept as an occupancy counter of parameterized depth. An instruction consumes tokens when it issues and produces tokens when its stage reports completion. A FINISH instruction that completes in the compute stage raises a sticky done flag. At that point any token left in a channel is reported as an error. Pushing a token into a full channel raises a sticky overflow flag.

Instruction encoding: opcode in bits [2:0] (LOAD=0, STORE=1, GEMM=2, FINISH=3, ALU=4). Flags: bit 3 pop-from-previous, bit 4 pop-from-next, bit 5 push-to-previous, bit 6 push-to-next. Memory type in bits [8:7] (micro-op=0, weight=1, input=2, accumulator=3). All other bits are carried through untouched.

Top module: `dispatch_top`

## Requirements
- R1: After reset no stage issues, `in_ready` is high and `run_done`, `err_overflow` and `err_leftover` are low.
- R2: An instruction with opcode STORE (1) goes to the store stage and appears unchanged on `st_insn` when `st_issue` is high.
- R3: A LOAD (opcode 0) whose memory type is weight (1) or input (2) goes to the load stage unchanged.
- R4: A LOAD for micro-op (0) or accumulator (3) memory, and every GEMM (2), FINISH (3) or ALU (4), goes to the compute stage unchanged.
- R5: `in_ready` is low only while the queue chosen by the presented instruction is full; instructions bound for other queues are still accepted.
- R6: A load with pop-from-next (bit 4) set does not issue until the compute-to-load channel holds a token, and its issue removes one token.
- R7: A load with push-to-next (bit 6) set adds one load-to-compute token when its stage completes.
- R8: A compute instruction issues only when the load-to-compute channel (if bit 3 is set) and the store-to-compute channel (if bit 4 is set) both hold a token, and it removes one from each channel it names.
- R9: On completion a compute instruction adds a compute-to-load token if bit 5 is set and a compute-to-store token if bit 6 is set.
- R10: A store with bit 3 set waits for a compute-to-store token and consumes it; with bit 5 set its completion adds a store-to-compute token.
- R11: A head instruction that cannot issue stalls only its own stage, and each stage has at most one instruction between issue and completion.
- R12: Completion of a FINISH in the compute stage sets `run_done`, which stays set until reset.
- R13: `err_leftover` is high whenever `run_done` is set and any token channel is non-empty.
- R14: A token pushed into a channel already holding TOK_DEPTH tokens, with no pop in the same cycle, sets `err_overflow` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_insn | input | 128 | Instruction word |
| ld_issue | output | 1 | Load stage issue pulse |
| ld_insn | output | 128 | Instruction issued to the load stage |
| ld_done | input | 1 | Load stage completion pulse |
| cp_issue | output | 1 | Compute stage issue pulse |
| cp_insn | output | 128 | Instruction issued to the compute stage |
| cp_done | input | 1 | Compute stage completion pulse |
| st_issue | output | 1 | Store stage issue pulse |
| st_insn | output | 128 | Instruction issued to the store stage |
| st_done | input | 1 | Store stage completion pulse |
| run_done | output | 1 | Sticky: FINISH completed |
| err_overflow | output | 1 | Sticky: push into a full token channel |
| err_leftover | output | 1 | Tokens remain at done |

## Verification
The bench builds the block with TOK_DEPTH=2 and Q_DEPTH=4. At these sizes a token channel fills after two completions, so the overflow flag is reached with three loads. A store queue saturates after four blocked stores, which makes back-pressure on one queue observable while another still accepts. The full opcode by memory-type grid of twenty routing cases is swept, and a scripted token exchange among the three stages drains every channel to zero before FINISH, with the expected values worked out from the token flow.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int INSN_W      = 128;
  localparam int NSTAGE      = 3;
  localparam int NTOK        = 4;
  // instruction field positions
  localparam int B_POP_PREV  = 3;
  localparam int B_POP_NEXT  = 4;
  localparam int B_PUSH_PREV = 5;
  localparam int B_PUSH_NEXT = 6;
  localparam int MEM_LSB     = 7;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_GEMM = 3'd2, OP_FINISH = 3'd3, OP_ALU = 3'd4
  } opcode_e;

  localparam logic [1:0] MT_UOP = 2'd0;
  localparam logic [1:0] MT_WGT = 2'd1;
  localparam logic [1:0] MT_INP = 2'd2;
  localparam logic [1:0] MT_ACC = 2'd3;

  // stage indices
  localparam int S_LD = 0;
  localparam int S_CP = 1;
  localparam int S_ST = 2;
  // token channel indices
  localparam int T_L2C = 0;
  localparam int T_C2L = 1;
  localparam int T_C2S = 2;
  localparam int T_S2C = 3;

  function automatic logic [1:0] route_of(input logic [INSN_W-1:0] insn);
    logic [1:0] mt;
    mt = insn[MEM_LSB +: 2];
    if (insn[2:0] == OP_STORE) return 2'(S_ST);
    if (insn[2:0] == OP_LOAD && (mt == MT_WGT || mt == MT_INP)) return 2'(S_LD);
    return 2'(S_CP);
  endfunction
endpackage

// File: rtl/dsp_insn_queue.sv
module dsp_insn_queue #(
  parameter int W     = 128,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         nonempty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop_i)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_i) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    else if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign head_o     = mem_q[rd_q];
  assign nonempty_o = (cnt_q != '0);
  assign full_o     = (cnt_q == CW'(DEPTH));

  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);
  a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/dsp_token_fifo.sv
module dsp_token_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  output logic nonempty_o,
  output logic ovf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full;

  assign full = (cnt_q == CW'(DEPTH));

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push_i && !pop_i) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (pop_i && !push_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign nonempty_o = (cnt_q != '0);
  assign ovf_o      = ovf_q;

  a_r8_no_token_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> nonempty_o);
  a_r14_overflow_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full) |=> ovf_o);
  a_r14_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

// File: rtl/dsp_stage_gate.sv
module dsp_stage_gate #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid_i,
  input  logic          need_a_i,
  input  logic          avail_a_i,
  input  logic          need_b_i,
  input  logic          avail_b_i,
  input  logic [MW-1:0] meta_i,
  input  logic          done_i,
  output logic          issue_o,
  output logic          fin_o,
  output logic [MW-1:0] meta_o
);
  logic          busy_q, busy_d;
  logic [MW-1:0] meta_q, meta_d;

  assign issue_o = head_valid_i && !busy_q &&
                   (!need_a_i || avail_a_i) && (!need_b_i || avail_b_i);
  assign fin_o   = done_i && busy_q;

  always_comb begin
    busy_d = busy_q;
    meta_d = meta_q;
    if (fin_o) busy_d = 1'b0;
    if (issue_o) begin
      busy_d = 1'b1;
      meta_d = meta_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      meta_q <= '0;
    end else begin
      busy_q <= busy_d;
      meta_q <= meta_d;
    end
  end

  assign meta_o = meta_q;

  a_r11_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !issue_o);
  a_r8_tokens_present_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> ((!need_a_i || avail_a_i) && (!need_b_i || avail_b_i)));
endmodule

// File: rtl/dispatch_top.sv
module dispatch_top
  import dispatch_pkg::*;
#(
  parameter int TOK_DEPTH = 4,
  parameter int Q_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  output logic              ld_issue,
  output logic [INSN_W-1:0] ld_insn,
  input  logic              ld_done,
  output logic              cp_issue,
  output logic [INSN_W-1:0] cp_insn,
  input  logic              cp_done,
  output logic              st_issue,
  output logic [INSN_W-1:0] st_insn,
  input  logic              st_done,
  output logic              run_done,
  output logic              err_overflow,
  output logic              err_leftover
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [INSN_W-1:0] q_head [NSTAGE];
  logic [NSTAGE-1:0] q_push, q_ne, q_full, iss, fin, done_vec;
  logic [NSTAGE-1:0] need_a, need_b, avail_a, avail_b;
  logic [2:0]        meta_in [NSTAGE];
  logic [2:0]        meta_q  [NSTAGE];
  logic [NTOK-1:0]   tok_push, tok_pop, tok_ne, tok_ovf;
  logic [1:0]        route;

  assign route    = route_of(in_insn);
  assign in_ready = !q_full[route];
  assign done_vec = {st_done, cp_done, ld_done};

  always_comb begin
    for (int s = 0; s < NSTAGE; s++) q_push[s] = in_valid && in_ready && (route == 2'(s));
  end

  // per-stage token wiring
  always_comb begin
    need_a = '0; need_b = '0; avail_a = '0; avail_b = '0;
    for (int s = 0; s < NSTAGE; s++) meta_in[s] = '0;
    need_b[S_LD]  = q_head[S_LD][B_POP_NEXT];
    avail_b[S_LD] = tok_ne[T_C2L];
    meta_in[S_LD] = {1'b0, q_head[S_LD][B_PUSH_NEXT], 1'b0};
    need_a[S_CP]  = q_head[S_CP][B_POP_PREV];
    avail_a[S_CP] = tok_ne[T_L2C];
    need_b[S_CP]  = q_head[S_CP][B_POP_NEXT];
    avail_b[S_CP] = tok_ne[T_S2C];
    meta_in[S_CP] = {q_head[S_CP][2:0] == OP_FINISH,
                     q_head[S_CP][B_PUSH_NEXT], q_head[S_CP][B_PUSH_PREV]};
    need_a[S_ST]  = q_head[S_ST][B_POP_PREV];
    avail_a[S_ST] = tok_ne[T_C2S];
    meta_in[S_ST] = {2'b00, q_head[S_ST][B_PUSH_PREV]};
  end

  always_comb begin
    tok_pop[T_C2L]  = iss[S_LD] && need_b[S_LD];
    tok_pop[T_L2C]  = iss[S_CP] && need_a[S_CP];
    tok_pop[T_S2C]  = iss[S_CP] && need_b[S_CP];
    tok_pop[T_C2S]  = iss[S_ST] && need_a[S_ST];
    tok_push[T_L2C] = fin[S_LD] && meta_q[S_LD][1];
    tok_push[T_C2L] = fin[S_CP] && meta_q[S_CP][0];
    tok_push[T_C2S] = fin[S_CP] && meta_q[S_CP][1];
    tok_push[T_S2C] = fin[S_ST] && meta_q[S_ST][0];
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    dsp_insn_queue #(.W(INSN_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_i), .push_i(q_push[s]), .data_i(in_insn),
      .pop_i(iss[s]), .head_o(q_head[s]), .nonempty_o(q_ne[s]), .full_o(q_full[s]));
    dsp_stage_gate #(.MW(3)) u_gate (
      .clk(clk), .rst_n(rst_i), .head_valid_i(q_ne[s]),
      .need_a_i(need_a[s]), .avail_a_i(avail_a[s]),
      .need_b_i(need_b[s]), .avail_b_i(avail_b[s]),
      .meta_i(meta_in[s]), .done_i(done_vec[s]),
      .issue_o(iss[s]), .fin_o(fin[s]), .meta_o(meta_q[s]));
  end

  for (genvar t = 0; t < NTOK; t++) begin : g_tok
    dsp_token_fifo #(.DEPTH(TOK_DEPTH)) u_tok (
      .clk(clk), .rst_n(rst_i), .push_i(tok_push[t]), .pop_i(tok_pop[t]),
      .nonempty_o(tok_ne[t]), .ovf_o(tok_ovf[t]));
  end

  logic unused_meta;
  assign unused_meta = ^{meta_q[S_LD][2], meta_q[S_LD][0], meta_q[S_ST][2:1]};

  logic done_q, done_d;
  always_comb begin
    done_d = done_q;
    if (fin[S_CP] && meta_q[S_CP][2]) done_d = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign run_done     = done_q;
  assign err_overflow = |tok_ovf;
  assign err_leftover = done_q && (|tok_ne);
  assign ld_issue = iss[S_LD];
  assign cp_issue = iss[S_CP];
  assign st_issue = iss[S_ST];
  assign ld_insn  = q_head[S_LD];
  assign cp_insn  = q_head[S_CP];
  assign st_insn  = q_head[S_ST];

  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    run_done |=> run_done);
  a_r2_store_enqueued: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready && in_insn[2:0] == OP_STORE) |=> q_ne[S_ST]);
  a_r3_load_enqueued: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready && in_insn[2:0] == OP_LOAD &&
     (in_insn[MEM_LSB +: 2] == MT_WGT || in_insn[MEM_LSB +: 2] == MT_INP)) |=> q_ne[S_LD]);
  a_r12_done_needs_compute_done: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(run_done) |-> $past(cp_done));
endmodule

// File: tb/tb_dispatch_top.sv
`timescale 1ns/1ps
module tb_dispatch_top;
  logic         clk, rst_n;
  logic         in_valid, in_ready;
  logic [127:0] in_insn;
  logic         ld_issue, cp_issue, st_issue;
  logic [127:0] ld_insn, cp_insn, st_insn;
  logic         ld_done, cp_done, st_done;
  logic         run_done, err_overflow, err_leftover;

  dispatch_top #(.TOK_DEPTH(2), .Q_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .ld_issue(ld_issue), .ld_insn(ld_insn), .ld_done(ld_done),
    .cp_issue(cp_issue), .cp_insn(cp_insn), .cp_done(cp_done),
    .st_issue(st_issue), .st_insn(st_insn), .st_done(st_done),
    .run_done(run_done), .err_overflow(err_overflow), .err_leftover(err_leftover));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int ld_cnt = 0, cp_cnt = 0, st_cnt = 0;
  logic [127:0] ld_last = '0, cp_last = '0, st_last = '0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input int op, input int mt, input bit pp, input bit pn,
                                      input bit hp, input bit hn, input int tag);
    logic [127:0] v;
    v = '0;
    v[2:0] = 3'(op); v[3] = pp; v[4] = pn; v[5] = hp; v[6] = hn; v[8:7] = 2'(mt);
    v[31:16] = 16'(tag);
    v[127:64] = {4{16'(tag) ^ 16'hA5C3}};
    return v;
  endfunction

  // stage models: fixed latency responders
  initial begin
    ld_done = 0;
    forever begin
      @(negedge clk); ld_done = 0;
      if (ld_issue) begin
        ld_cnt++; ld_last = ld_insn;
        repeat (1) @(negedge clk); ld_done = 1;
      end
    end
  end
  initial begin
    cp_done = 0;
    forever begin
      @(negedge clk); cp_done = 0;
      if (cp_issue) begin
        cp_cnt++; cp_last = cp_insn;
        repeat (2) @(negedge clk); cp_done = 1;
      end
    end
  end
  initial begin
    st_done = 0;
    forever begin
      @(negedge clk); st_done = 0;
      if (st_issue) begin
        st_cnt++; st_last = st_insn;
        repeat (1) @(negedge clk); st_done = 1;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; in_insn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [127:0] v);
    @(negedge clk);
    in_valid = 1; in_insn = v;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int l0, c0, s0, got, exp_st;
    logic [127:0] v;
    rst_n = 0; in_valid = 0; in_insn = '0;
    do_reset();
    #1;
    // R1 reset state
    check(!ld_issue && !cp_issue && !st_issue, "R1 issue idle", {ld_issue, cp_issue, st_issue}, 0);
    check(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    check(!run_done && !err_overflow && !err_leftover, "R1 flags",
          {run_done, err_overflow, err_leftover}, 0);

    // R2/R3/R4 routing sweep over opcode x memory type
    for (int op = 0; op < 5; op++) begin
      for (int mt = 0; mt < 4; mt++) begin
        l0 = ld_cnt; c0 = cp_cnt; s0 = st_cnt;
        v = mk(op, mt, 0, 0, 0, 0, op * 4 + mt + 1);
        send(v);
        settle(8);
        if (op == 1) exp_st = 2;
        else if (op == 0 && (mt == 1 || mt == 2)) exp_st = 0;
        else exp_st = 1;
        got = 9;
        if (ld_cnt == l0 + 1 && cp_cnt == c0 && st_cnt == s0 && ld_last == v) got = 0;
        if (cp_cnt == c0 + 1 && ld_cnt == l0 && st_cnt == s0 && cp_last == v) got = 1;
        if (st_cnt == s0 + 1 && ld_cnt == l0 && cp_cnt == c0 && st_last == v) got = 2;
        if (exp_st == 2)      check(got == exp_st, "R2 store route", got, exp_st);
        else if (exp_st == 0) check(got == exp_st, "R3 load route", got, exp_st);
        else                  check(got == exp_st, "R4 compute route", got, exp_st);
      end
    end

    // token exchange among stages
    do_reset();
    l0 = ld_cnt; c0 = cp_cnt; s0 = st_cnt;
    send(mk(0, 2, 0, 1, 0, 1, 101));                 // load waits on compute-to-load
    settle(8);
    check(ld_cnt == l0, "R6 load blocked without token", ld_cnt - l0, 0);
    send(mk(1, 0, 0, 0, 0, 0, 102));                 // store, no flags
    settle(8);
    check(st_cnt == s0 + 1, "R11 store proceeds while load stalled", st_cnt - s0, 1);
    send(mk(2, 0, 0, 0, 1, 0, 103));                 // compute pushes compute-to-load
    settle(10);
    check(cp_cnt == c0 + 1, "R9 compute issues", cp_cnt - c0, 1);
    check(ld_cnt == l0 + 1, "R6 load released by token", ld_cnt - l0, 1);
    send(mk(4, 0, 1, 0, 0, 1, 104));                 // ALU pops load-to-compute, pushes compute-to-store
    settle(10);
    check(cp_cnt == c0 + 2, "R7 load completion token feeds compute", cp_cnt - c0, 2);
    send(mk(1, 0, 1, 0, 1, 0, 105));                 // store pops compute-to-store, pushes store-to-compute
    settle(8);
    check(st_cnt == s0 + 2, "R10 store consumes compute token", st_cnt - s0, 2);
    send(mk(2, 0, 0, 1, 0, 0, 106));                 // compute pops store-to-compute
    settle(10);
    check(cp_cnt == c0 + 3, "R8 compute takes store token", cp_cnt - c0, 3);
    send(mk(2, 0, 1, 0, 0, 0, 107));                 // compute waits on load-to-compute
    settle(10);
    check(cp_cnt == c0 + 3, "R8 compute blocked without token", cp_cnt - c0, 3);
    send(mk(0, 1, 0, 0, 0, 1, 108));                 // weight load produces token
    settle(12);
    check(ld_cnt == l0 + 2, "R3 weight load issues", ld_cnt - l0, 2);
    check(cp_cnt == c0 + 4, "R7 compute released", cp_cnt - c0, 4);
    check(!run_done, "R12 done low before finish", run_done, 0);
    send(mk(3, 0, 0, 0, 0, 0, 109));
    settle(10);
    check(run_done, "R12 done after finish", run_done, 1);
    check(!err_leftover, "R13 no leftover when drained", err_leftover, 0);
    check(!err_overflow, "R14 no overflow in exchange", err_overflow, 0);
    settle(5);
    check(run_done, "R12 done sticky", run_done, 1);

    // leftover token at done
    do_reset();
    send(mk(0, 2, 0, 0, 0, 1, 201));
    settle(6);
    send(mk(3, 0, 0, 0, 0, 0, 202));
    settle(10);
    check(run_done && err_leftover, "R13 leftover flagged", {run_done, err_leftover}, 3);

    // overflow of a depth-2 channel
    do_reset();
    send(mk(0, 2, 0, 0, 0, 1, 301));
    send(mk(0, 2, 0, 0, 0, 1, 302));
    settle(8);
    check(!err_overflow, "R14 two tokens fit", err_overflow, 0);
    send(mk(0, 2, 0, 0, 0, 1, 303));
    settle(8);
    check(err_overflow, "R14 third token overflows", err_overflow, 1);

    // back-pressure of a single queue
    do_reset();
    s0 = st_cnt; l0 = ld_cnt;
    for (int i = 0; i < 4; i++) send(mk(1, 0, 1, 0, 0, 0, 400 + i));
    settle(4);
    @(negedge clk);
    in_valid = 1; in_insn = mk(1, 0, 1, 0, 0, 0, 410);
    #1;
    check(!in_ready, "R5 full store queue refuses", in_ready, 0);
    in_insn = mk(0, 2, 0, 0, 0, 0, 411);
    #1;
    check(in_ready, "R5 load accepted meanwhile", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    settle(8);
    check(ld_cnt == l0 + 1, "R5 load went through", ld_cnt - l0, 1);
    check(st_cnt == s0, "R10 stores wait for token", st_cnt - s0, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule